// File: doc/BRIEF.md
# Two-Pass Memory Self-Test Engine

This controller exercises a word-addressable memory through a request/response stream. A rising edge on `start` launches a run with two passes. The first pass stores a pattern derived from the address at every location from 0 up to `LAST_ADDR`. The pattern is the address modulo 256, zero-extended to the data width. After the last location has been written, the address counter returns to zero. The second pass then reads each location back and compares the returned word with the same pattern. The run stops at the first mismatch and records that address. If every location matches, the run reports success.

Every write completes before the first read is issued. As a result, a memory whose data bus floats cannot pass by echoing the value that was just written to the same address.

The request channel is valid/ready. While `req_valid` is high and `req_ready` is low, the engine holds the address, the write flag and the write data unchanged. A request is consumed on the cycle where both signals are high. The response channel has no ready signal. The engine keeps exactly one read in flight and waits as many cycles as needed for `rsp_valid`, so it always accepts the response. The memory may answer a read no sooner than one cycle after accepting it.

Top module: `mem_selftest`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `busy`, `done`, `pass` and `req_valid` are 0.
- R2: A rising edge of `start` when the engine is idle starts a write pass. The write pass issues exactly one accepted write (`req_write`=1) to each address 0,1,…,`LAST_ADDR` in ascending order. Each write carries `req_wdata` = address mod 256 with all bits above bit 7 zero.
- R3: The read pass begins only after the write to `LAST_ADDR` has been accepted. It reads addresses 0,1,… in ascending order. No new request is issued while a read is awaiting `rsp_valid`.
- R4: While `req_valid`=1 and `req_ready`=0, the next cycle keeps `req_valid` high with the same `req_addr`, `req_write` and `req_wdata`.
- R5: A response whose full `rsp_data` word differs from the expected pattern ends the run: `done`=1, `pass`=0, `fail_addr` = the address just read, and no further requests follow.
- R6: A run whose read of `LAST_ADDR` matches ends with `done`=1, `pass`=1 and `fail_addr`=0.
- R7: `done`, `pass` and `fail_addr` keep their values until the next rising edge of `start`. Holding `start` high does not begin a new run.
- R8: Rising edges of `start` while `busy`=1 have no effect. The run completes with a single write pass.
- R9: `busy` is 1 from the cycle after the accepted `start` edge until the result is posted. `busy` and `done` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | A rising edge launches a run when idle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | A result is posted and held |
| pass | output | 1 | The last run matched at every address |
| fail_addr | output | ADDR_W | First mismatching address (0 on success) |
| req_valid | output | 1 | Request channel valid |
| req_ready | input | 1 | Memory accepts the request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | ADDR_W | Request address |
| req_wdata | output | DATA_W | Write data |
| rsp_valid | input | 1 | Read data present (one cycle pulse) |
| rsp_data | input | DATA_W | Read data |

## Verification
The memory model is run in several ways:
- A healthy memory, with and without back-pressure and extra read latency. This separates correct handshaking from lucky timing.
- A bit flip at address 0, at the last address and at address 256. These show that the comparison boundaries and the mod-256 wrap are right.
- A flip in a bit above bit 7. This shows that the whole word is compared against a zero-extended pattern.
- A dropped write. This tells a stored value apart from a stale one.
- A floating bus that returns the last word driven. This fails only because the passes are separated.

Further tests cover reset, a `start` held high, and `start` pulses during a run.

// File: rtl/mst_pkg.sv
package mst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2,
    ST_WAIT  = 2'd3
  } mst_state_e;
endpackage

// File: rtl/mst_addr_counter.sv
module mst_addr_counter #(
  parameter int ADDR_W    = 9,
  parameter int LAST_ADDR = 299
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  output logic [ADDR_W-1:0] cnt,
  output logic              at_last
);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST_ADDR);

  logic [ADDR_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt     = cnt_q;
  assign at_last = (cnt_q == LAST_A);
endmodule

// File: rtl/mst_pattern.sv
module mst_pattern #(
  parameter int PW     = 8,
  parameter int DATA_W = 12
) (
  input  logic [PW-1:0]     addr_lo,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] pattern,
  output logic              match
);
  generate
    if (DATA_W > PW) begin : g_ext
      assign pattern = {{(DATA_W-PW){1'b0}}, addr_lo};
    end else begin : g_flat
      assign pattern = addr_lo;
    end
  endgenerate

  assign match = (rdata == pattern);
endmodule

// File: rtl/mst_ctrl.sv
module mst_ctrl
  import mst_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_rise,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic              at_last,
  input  logic              match,
  input  logic [ADDR_W-1:0] cnt,
  output logic              cnt_clr,
  output logic              cnt_inc,
  output logic              req_valid,
  output logic              req_write,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] fail_addr
);
  mst_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      done      <= 1'b0;
      pass      <= 1'b0;
      fail_addr <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_rise) begin
          state_q   <= ST_WRITE;
          done      <= 1'b0;
          pass      <= 1'b0;
          fail_addr <= '0;
        end
        ST_WRITE: if (req_ready && at_last) state_q <= ST_READ;
        ST_READ:  if (req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (rsp_valid) begin
          if (!match) begin
            state_q   <= ST_IDLE;
            done      <= 1'b1;
            fail_addr <= cnt;
          end else if (at_last) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
            pass    <= 1'b1;
          end else begin
            state_q <= ST_READ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cnt_clr = ((state_q == ST_IDLE) && start_rise) ||
              ((state_q == ST_WRITE) && req_ready && at_last);
    cnt_inc = ((state_q == ST_WRITE) && req_ready && !at_last) ||
              ((state_q == ST_WAIT) && rsp_valid && match && !at_last);
  end

  assign req_valid = (state_q == ST_WRITE) || (state_q == ST_READ);
  assign req_write = (state_q == ST_WRITE);
  assign busy      = (state_q != ST_IDLE);
endmodule

// File: rtl/mem_selftest.sv
module mem_selftest #(
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 12,
  parameter int LAST_ADDR = 299
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] fail_addr,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data
);
  localparam int PW = (ADDR_W < 8) ? ADDR_W : 8;

  logic              start_q;
  logic              start_rise;
  logic              cnt_clr, cnt_inc, at_last, match;
  logic [ADDR_W-1:0] cnt;
  logic [DATA_W-1:0] pattern;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start;
  end
  assign start_rise = start && !start_q;

  mst_addr_counter #(.ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
    .cnt(cnt), .at_last(at_last)
  );

  mst_pattern #(.PW(PW), .DATA_W(DATA_W)) u_pat (
    .addr_lo(cnt[PW-1:0]), .rdata(rsp_data), .pattern(pattern), .match(match)
  );

  mst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_rise(start_rise),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .at_last(at_last),
    .match(match), .cnt(cnt), .cnt_clr(cnt_clr), .cnt_inc(cnt_inc),
    .req_valid(req_valid), .req_write(req_write), .busy(busy),
    .done(done), .pass(pass), .fail_addr(fail_addr)
  );

  assign req_addr  = cnt;
  assign req_wdata = pattern;
endmodule

// File: rtl/mem_selftest_chk.sv
module mem_selftest_chk #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic [ADDR_W-1:0] fail_addr,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid
);
  localparam int PW = (ADDR_W < 8) ? ADDR_W : 8;

  logic              start_prev, in_flight, read_seen;
  logic [DATA_W-1:0] exp_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_prev <= 1'b0;
      in_flight  <= 1'b0;
      read_seen  <= 1'b0;
    end else begin
      start_prev <= start;
      if (req_valid && req_ready && !req_write) in_flight <= 1'b1;
      else if (rsp_valid)                       in_flight <= 1'b0;
      if (!busy)                                     read_seen <= 1'b0;
      else if (req_valid && req_ready && !req_write) read_seen <= 1'b1;
    end
  end

  always_comb begin
    exp_w = '0;
    for (int i = 0; i < PW; i++) exp_w[i] = req_addr[i];
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_wdata)); // R4
  AST_WDATA_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |-> req_wdata == exp_w); // R2
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    in_flight |-> !req_valid); // R3
  AST_NO_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    read_seen |-> !(req_valid && req_write)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid); // R5
  AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done && fail_addr == '0); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !(start && !start_prev) |=> done && $stable(pass) && $stable(fail_addr)); // R7
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> busy || done); // R8
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R9
endmodule

bind mem_selftest mem_selftest_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_mem_selftest.sv
module tb_mem_selftest;
  localparam int AW = 9, DW = 12, LAST = 299;

  typedef struct packed {
    logic [1:0]    mode;   // 0 clean, 1 bit flip, 2 dropped write, 3 floating bus
    logic [AW-1:0] faddr;
    logic [DW-1:0] mask;
    logic          stall;
    logic          exp_pass;
    logic [AW-1:0] exp_fail;
    logic [7:0]    req;    // requirement number for messages
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 9'd0,   12'h000, 1'b0, 1'b1, 9'd0,   8'd6},
    '{2'd0, 9'd0,   12'h000, 1'b1, 1'b1, 9'd0,   8'd4},
    '{2'd1, 9'd0,   12'h001, 1'b0, 1'b0, 9'd0,   8'd5},
    '{2'd1, 9'd299, 12'h080, 1'b1, 1'b0, 9'd299, 8'd5},
    '{2'd1, 9'd256, 12'h001, 1'b0, 1'b0, 9'd256, 8'd2},
    '{2'd2, 9'd137, 12'h000, 1'b1, 1'b0, 9'd137, 8'd5},
    '{2'd3, 9'd0,   12'h000, 1'b0, 1'b0, 9'd0,   8'd3},
    '{2'd1, 9'd50,  12'h800, 1'b0, 1'b0, 9'd50,  8'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, pass, req_valid, req_ready, req_write, rsp_valid;
  logic [AW-1:0] fail_addr, req_addr;
  logic [DW-1:0] req_wdata, rsp_data;

  always #2 clk = ~clk;

  mem_selftest #(.ADDR_W(AW), .DATA_W(DW), .LAST_ADDR(LAST)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .pass(pass), .fail_addr(fail_addr), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  // memory model and bus monitor
  logic [1:0]    m_mode = 2'd0;
  logic [AW-1:0] m_faddr = '0;
  logic [DW-1:0] m_mask = '0;
  logic          m_stall = 1'b0, mon_clr = 1'b0;
  logic [DW-1:0] mem [0:LAST];
  logic [DW-1:0] last_w = '0, pend_d = '0;
  logic          pend = 1'b0;
  logic [1:0]    pend_n = '0;
  logic [3:0]    rdy_lfsr = 4'h9;
  int            n_wr = 0, n_rd = 0, order_err = 0, data_err = 0;
  logic          rd_seen = 1'b0;

  assign req_ready = m_stall ? rdy_lfsr[0] : 1'b1;

  always @(posedge clk) begin
    rdy_lfsr <= {rdy_lfsr[2:0], rdy_lfsr[3] ^ rdy_lfsr[2]};
    rsp_valid <= 1'b0;
    if (mon_clr) begin
      for (int i = 0; i <= LAST; i++) mem[i] <= '1;
      n_wr <= 0; n_rd <= 0; order_err <= 0; data_err <= 0; rd_seen <= 1'b0;
      pend <= 1'b0; last_w <= '0;
    end else begin
      if (pend) begin
        if (pend_n == 0) begin rsp_valid <= 1'b1; rsp_data <= pend_d; pend <= 1'b0; end
        else pend_n <= pend_n - 1'b1;
      end
      if (req_valid && req_ready) begin
        if (req_write) begin
          if (rd_seen || req_addr != AW'(n_wr)) order_err <= order_err + 1;
          if (req_wdata != DW'(n_wr % 256)) data_err <= data_err + 1;
          if (req_addr <= AW'(LAST) && !(m_mode == 2'd2 && req_addr == m_faddr))
            mem[req_addr] <= req_wdata;
          last_w <= req_wdata;
          n_wr <= n_wr + 1;
        end else begin
          if (req_addr != AW'(n_rd) || pend) order_err <= order_err + 1;
          rd_seen <= 1'b1;
          n_rd <= n_rd + 1;
          pend <= 1'b1;
          pend_n <= m_stall ? 2'd2 : 2'd0;
          if (m_mode == 2'd3) pend_d <= last_w;
          else if (req_addr > AW'(LAST)) pend_d <= '1;
          else pend_d <= mem[req_addr] ^ ((m_mode == 2'd1 && req_addr == m_faddr) ? m_mask : '0);
        end
      end
    end
  end

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic finished = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      n_fail++;
      $display("FAIL R9: watchdog expired, actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic clear_mon();
    @(negedge clk) mon_clr = 1'b1;
    @(negedge clk) mon_clr = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    chk(req, int'(done), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 req_valid in reset", int'(req_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 pass after reset", int'(pass), 0);
    chk("R1 req_valid after reset", int'(req_valid), 0);

    // vector table
    for (int v = 0; v < 8; v++) begin
      m_mode = VECS[v].mode; m_faddr = VECS[v].faddr;
      m_mask = VECS[v].mask; m_stall = VECS[v].stall;
      clear_mon();
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk("R9 busy after start", int'(busy), 1);
      chk("R9 done cleared at start", int'(done), 0);
      wait_done("R9 run ends");
      chk($sformatf("R%0d pass v%0d", VECS[v].req, v), int'(pass), int'(VECS[v].exp_pass));
      chk($sformatf("R%0d fail_addr v%0d", VECS[v].req, v), int'(fail_addr), int'(VECS[v].exp_fail));
      chk("R2 write count", n_wr, LAST + 1);
      chk("R2 write data mod 256", data_err, 0);
      chk("R3 ordering", order_err, 0);
      chk("R5 reads up to failing address",
          n_rd, VECS[v].exp_pass ? LAST + 1 : int'(VECS[v].exp_fail) + 1);
    end

    // R7: start held high through a whole run, result holds, no rerun
    m_mode = 2'd1; m_faddr = 9'd7; m_mask = 12'h004; m_stall = 1'b0;
    clear_mon();
    start = 1'b1;
    @(negedge clk);
    wait_done("R7 run ends");
    repeat (20) @(negedge clk);
    chk("R7 done held", int'(done), 1);
    chk("R7 fail_addr held", int'(fail_addr), 7);
    chk("R7 no rerun while start high", n_wr, LAST + 1);
    chk("R7 busy stays low", int'(busy), 0);
    start = 1'b0;

    // R8: start pulses during a run are ignored
    m_mode = 2'd0; m_stall = 1'b1;
    clear_mon();
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (10) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (400) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_done("R8 run ends");
    chk("R8 single write pass", n_wr, LAST + 1);
    chk("R8 pass", int'(pass), 1);
    repeat (10) @(negedge clk);
    chk("R8 no late restart", int'(busy), 0);
    chk("R6 fail_addr zero on success", int'(fail_addr), 0);

    // R1: reset in the middle of a run
    clear_mon();
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 busy after mid-run reset", int'(busy), 0);
    chk("R1 req_valid after mid-run reset", int'(req_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after mid-run reset", int'(done), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule